// File: doc/BRIEF.md
# Square-Root Carry Select Adder

This block adds two unsigned operands of `WIDTH` bits and a single carry-in, and returns a `WIDTH`-bit sum with a carry-out. It is purely combinational: no clock, no reset and no storage. A result is valid one propagation delay after the inputs settle.

The operand is split into groups whose lengths grow toward the most significant end.

- The lowest group is a plain ripple adder fed by the external carry-in.
- Every higher group ripples its bits once, assuming an incoming carry of zero.
- A second candidate assumes an incoming carry of one. The carry arriving from the group below then picks between the two candidates.
- By default the carry-one candidate is derived from the carry-zero result by an increment-by-one converter.
- With `USE_BEC` cleared, a second ripple adder with its carry-in tied high produces the carry-one candidate instead. This regular form is kept for area and delay comparison.

Top module: `sqrt_csla`

## Requirements
- R1: For every input, {cout_o, sum_o} equals the (WIDTH+1)-bit sum a_i + b_i + cin_i.
- R2: WIDTH may be 16, 32 or 64. The group sizes, from the least significant group upward, are:
  - 16 bits: 2,2,3,4,5
  - 32 bits: 2,2,3,4,5,7,9
  - 64 bits: 2,2,3,4,5,6,7,8,12,15
  
  Any other width is rejected.
- R3: sum_o[1:0] depends only on a_i[1:0], b_i[1:0] and cin_i, because the lowest 2-bit group is a ripple adder.
- R4: A carry produced below any bit position k reaches bit k for every group boundary. With a_i = 2^k-1, b_i = 1 and cin_i = 0, the result is sum_o = 2^k, and sum_o = 0 with cout_o = 1 when k = WIDTH.
- R5: With a_i all ones, b_i = 0 and cin_i = 1, the result is sum_o = 0 and cout_o = 1. With cin_i = 0 the same operands give sum_o all ones and cout_o = 0.
- R6: With all inputs zero, the result is sum_o = 0 and cout_o = 0.
- R7: USE_BEC = 0 (pair of ripple adders per group) and USE_BEC = 1 (increment converter) give identical outputs for identical inputs.
- R8: cout_o is the selected carry of the top group. When cout_o = 1, sum_o <= a_i. When cout_o = 0, sum_o >= a_i.
- R9: The outputs follow the inputs without any clock edge, within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The assertions assume the inputs are fully known two-state values and are sampled only after the combinational paths settle. They therefore say nothing about glitches while a carry is still selecting. The bench changes inputs on the falling edge of its clock and samples 1 ns later, when all groups have resolved. It drives the same operand to all six width/style builds at once, truncated to each width, so every vector stays legal for every build.

// File: rtl/sqrt_csla_pkg.sv
package sqrt_csla_pkg;

  function automatic int grp_count(input int w);
    case (w)
      16:      return 5;
      32:      return 7;
      default: return 10;
    endcase
  endfunction

  // group sizes grow toward the MSB end
  function automatic int grp_size(input int w, input int g);
    case (g)
      0, 1: return 2;
      2:    return 3;
      3:    return 4;
      4:    return 5;
      default: begin
        if (w == 32) return (g == 5) ? 7 : 9;
        case (g)
          5:       return 6;
          6:       return 7;
          7:       return 8;
          8:       return 12;
          default: return 15;
        endcase
      end
    endcase
  endfunction

  function automatic int grp_lsb(input int w, input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += grp_size(w, i);
    return acc;
  endfunction

endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
  parameter int W = 4
) (
  input  logic [W-1:0] s_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  // ones[i]: all bits below i are set
  logic [W:0] ones;
  assign ones[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_inc
    assign s_o[i]    = s_i[i] ^ ones[i];
    assign ones[i+1] = ones[i] & s_i[i];
  end

  assign c_o = c_i ^ ones[W];
endmodule

// File: rtl/csla_group.sv
module csla_group #(
  parameter int W       = 4,
  parameter bit USE_BEC = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  csla_rca #(.W(W)) u_rca0 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(s0), .cout_o(c0)
  );

  if (USE_BEC) begin : g_bec
    csla_bec #(.W(W)) u_bec (
      .s_i(s0), .c_i(c0), .s_o(s1), .c_o(c1)
    );
  end else begin : g_rca1
    csla_rca #(.W(W)) u_rca1 (
      .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(s1), .cout_o(c1)
    );
  end

  assign sum_o  = sel_i ? s1 : s0;
  assign cout_o = sel_i ? c1 : c0;
endmodule

// File: rtl/sqrt_csla.sv
module sqrt_csla
  import sqrt_csla_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit USE_BEC = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = grp_count(WIDTH);

  logic [NGRP:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LSB = grp_lsb(WIDTH, g);
    localparam int SZ  = grp_size(WIDTH, g);
    if (g == 0) begin : g_low
      csla_rca #(.W(SZ)) u_rca (
        .a_i(a_i[LSB +: SZ]), .b_i(b_i[LSB +: SZ]), .cin_i(carry[0]),
        .sum_o(sum_o[LSB +: SZ]), .cout_o(carry[1])
      );
    end else begin : g_sel
      csla_group #(.W(SZ), .USE_BEC(USE_BEC)) u_grp (
        .a_i(a_i[LSB +: SZ]), .b_i(b_i[LSB +: SZ]), .sel_i(carry[g]),
        .sum_o(sum_o[LSB +: SZ]), .cout_o(carry[g+1])
      );
    end
  end

  assign cout_o = carry[NGRP];
endmodule

// File: rtl/sqrt_csla_chk.sv
module sqrt_csla_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  logic [WIDTH:0] ref_full;
  logic [2:0]     ref_low;

  initial begin
    assert_width_R2: assert (WIDTH == 16 || WIDTH == 32 || WIDTH == 64);
  end

  always_comb begin
    ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    ref_low  = {1'b0, a_i[1:0]} + {1'b0, b_i[1:0]} + {2'b00, cin_i};
    assert_sum_R1: assert ({cout_o, sum_o} == ref_full);
    assert_low_grp_R3: assert (sum_o[1:0] == ref_low[1:0]);
    if (a_i == '1 && b_i == '0 && cin_i)
      assert_all_ones_R5: assert (sum_o == '0 && cout_o);
    if (a_i == '0 && b_i == '0 && !cin_i)
      assert_zero_R6: assert (sum_o == '0 && !cout_o);
    if (cout_o)
      assert_wrap_R8: assert (sum_o <= a_i);
    else
      assert_nowrap_R8: assert (sum_o >= a_i);
  end
endmodule

bind sqrt_csla sqrt_csla_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/tb_sqrt_csla.sv
module tb_sqrt_csla;
  localparam int NCFG = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [63:0] a_r, b_r;
  logic        cin_r;
  logic [63:0] sum_all [NCFG];
  logic        cout_all [NCFG];
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  function automatic int cfg_w(input int i);
    return (i / 2 == 0) ? 16 : (i / 2 == 1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam int W = (g / 2 == 0) ? 16 : (g / 2 == 1) ? 32 : 64;
    logic [W-1:0] s;
    logic         co;
    sqrt_csla #(.WIDTH(W), .USE_BEC(g % 2 == 1)) dut (
      .a_i(a_r[W-1:0]), .b_i(b_r[W-1:0]), .cin_i(cin_r),
      .sum_o(s), .cout_o(co)
    );
    assign sum_all[g]  = 64'(s);
    assign cout_all[g] = co;
  end

  // drive on falling edge, sample 1 ns later (no clock edge involved: R9)
  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic c, input string req);
    @(negedge clk);
    a_r = a; b_r = b; cin_r = c;
    #1;
    for (int i = 0; i < NCFG; i++) begin
      logic [63:0] m;
      logic [64:0] full;
      logic [63:0] es;
      logic        ec;
      m    = wmask(cfg_w(i));
      full = {1'b0, a & m} + {1'b0, b & m} + {64'd0, c};
      es   = full[63:0] & m;
      ec   = full[cfg_w(i)];
      n_chk++;
      if (sum_all[i] != es || cout_all[i] != ec) begin
        n_err++;
        $display("FAIL %s cfg%0d w%0d: got sum=%h cout=%b exp sum=%h cout=%b",
                 req, i, cfg_w(i), sum_all[i], cout_all[i], es, ec);
      end
    end
  endtask

  initial begin
    int seed;
    logic [63:0] ra, rb;
    logic [1:0]  low_ref [NCFG];
    seed = 32'h5eed;
    void'($urandom(seed));
    a_r = '0; b_r = '0; cin_r = 1'b0;

    apply(64'd0, 64'd0, 1'b0, "R6");                // zero state
    apply('1, 64'd0, 1'b1, "R5");                    // all ones + carry-in
    apply('1, 64'd0, 1'b0, "R5");
    apply(64'd0, '1, 1'b1, "R5");
    for (int k = 1; k <= 64; k++)                    // every boundary (R4)
      apply((k == 64) ? '1 : ((64'd1 << k) - 64'd1), 64'd1, 1'b0, "R4");

    // R3: low two bits unchanged when only upper bits vary
    apply(64'h3, 64'h2, 1'b1, "R3");
    for (int i = 0; i < NCFG; i++) low_ref[i] = sum_all[i][1:0];
    apply(64'hfedc_ba98_7654_3213, 64'h0123_4567_89ab_cdee, 1'b1, "R3");
    for (int i = 0; i < NCFG; i++) begin
      n_chk++;
      if (sum_all[i][1:0] != low_ref[i]) begin
        n_err++;
        $display("FAIL R3 cfg%0d: got low=%b exp low=%b", i, sum_all[i][1:0], low_ref[i]);
      end
    end

    for (int n = 0; n < 3000; n++) begin             // R1 random, both carry-ins
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      apply(ra, rb, n[0], "R1");
      // R7: regular and converter builds agree; R8: wrap relation
      for (int i = 0; i < NCFG; i += 2) begin
        n_chk++;
        if (sum_all[i] != sum_all[i+1] || cout_all[i] != cout_all[i+1]) begin
          n_err++;
          $display("FAIL R7 w%0d: got reg=%h/%b exp bec=%h/%b", cfg_w(i),
                   sum_all[i], cout_all[i], sum_all[i+1], cout_all[i+1]);
        end
        n_chk++;
        if (cout_all[i+1] ? (sum_all[i+1] > (ra & wmask(cfg_w(i))))
                          : (sum_all[i+1] < (ra & wmask(cfg_w(i))))) begin
          n_err++;
          $display("FAIL R8 w%0d: got sum=%h cout=%b exp relation to a=%h",
                   cfg_w(i), sum_all[i+1], cout_all[i+1], ra & wmask(cfg_w(i)));
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule